// File: doc/BRIEF.md
# Bufferless Cut-Through Packet Crossbar

This block is the packet crossbar inside one cluster of a star-connected on-chip network. A set of source ports faces a set of sink ports. Every packet starts with a header flit that names the sink port and gives a burst-length code. The crossbar decodes the header and a round-robin arbiter for that sink picks one source. The chosen source then streams straight through to the sink. The switch holds no storage for flits. One instance is built for the request direction and a separate instance for the response direction.

Because nothing is buffered, a source that has not been granted is held off with its ready signal low. A granted source sees the sink's ready combinationally, so back-pressure passes through the crossbar in the same cycle. The path is held for exactly the number of flits that the burst code gives, and then it is released. The block outputs an enable vector for the crossbar rows (sources) and another for the columns (sinks). Power logic can use these to gate every segment that is not on a live path.

Top module: `xbar_switch`

## Requirements
- R1: During and directly after reset, every out_valid, in_ready, row_en and col_en bit is 0.
- R2: A packet is routed to the output whose index equals header bits [DST_LSB+1:DST_LSB] (two bits with the default four outputs). Every flit, the header included, appears on that output unchanged and in order.
- R3: A path carries exactly 1 + 2^code flits, where code is header bits [BL_LSB+1:BL_LSB] (code 0..3 gives 2, 3, 5 or 9 flits). The path is released at the clock edge that accepts the last flit, and an output cannot receive a new grant while it holds a path.
- R4: A header that requests an idle output is granted at the next clock edge. The header itself is not accepted in the cycle in which it requests (in_ready stays 0).
- R5: When several inputs request one free output, the grant goes to the first requester in cyclic order, starting from the input after the one last granted on that output. The pointer starts at input 0 after reset.
- R6: An input that holds no path has in_ready = 0.
- R7: A granted input's in_ready equals its output's out_ready. While out_ready is 0, no flit is consumed and the path stays held.
- R8: row_en[i] is 1 exactly when input i holds a path, and col_en[o] is 1 exactly when output o holds a path. The number of set row bits always equals the number of set column bits.
- R9: While a path is held, out_valid and out_data follow the granted input in the same cycle, with no register stage in between.
- R10: An output that holds no path drives out_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N_IN | Flit valid per source port |
| in_data | input | N_IN x W | Flit per source port |
| in_ready | output | N_IN | Flit accepted per source port |
| out_valid | output | N_OUT | Flit valid per sink port |
| out_data | output | N_OUT x W | Flit per sink port |
| out_ready | input | N_OUT | Sink can take a flit |
| row_en | output | N_IN | Crossbar row active |
| col_en | output | N_OUT | Crossbar column active |

## Verification
The properties assume that a source keeps valid high and its header steady from the moment it requests until the grant, and that each packet sends exactly the number of flits its burst code announces. They also assume every destination field names an existing output. The stimulus keeps to these rules. Each source drives one packet at a time through a task that counts flits from the header's own code, and every randomly drawn destination comes from the valid output range. Random sink stalls, parallel packets to different sinks and a directed contention round on one sink push against the back-pressure, pairing and fairness rules.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int BL_W  = 2;
  localparam int LEN_W = 4;

  // total flits of a packet: one header plus 2^code payload flits
  function automatic logic [LEN_W-1:0] flits_for_burst(input logic [BL_W-1:0] code);
    return LEN_W'(1) + (LEN_W'(1) << code);
  endfunction
endpackage

// File: rtl/xbar_route_decode.sv
module xbar_route_decode
  import xbar_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int DST_W = 2
) (
  input  logic [N_IN-1:0][DST_W-1:0] dst_f,
  input  logic [N_IN-1:0][BL_W-1:0]  bl_f,
  output logic [N_IN-1:0][N_OUT-1:0] dest_oh,
  output logic [N_IN-1:0][LEN_W-1:0] pkt_len
);
  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      pkt_len[i] = flits_for_burst(bl_f[i]);
      for (int o = 0; o < N_OUT; o++)
        dest_oh[i][o] = (dst_f[i] == DST_W'(o));
    end
  end
endmodule

// File: rtl/xbar_rr_arbiter.sv
module xbar_rr_arbiter #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  output logic             gnt_vld,
  output logic [IDX_W-1:0] gnt_idx
);
  logic [IDX_W-1:0] ptr;

  // returns {found, index}: first request at or after the start index
  function automatic logic [IDX_W:0] rr_pick(input logic [N-1:0] r, input logic [IDX_W-1:0] start);
    logic [IDX_W:0] res;
    res = '0;
    for (int k = 0; k < N; k++) begin
      int c;
      c = (int'(start) + k) % N;
      if (!res[IDX_W] && r[c]) res = {1'b1, IDX_W'(c)};
    end
    return res;
  endfunction

  logic [IDX_W:0] pick;
  assign pick    = rr_pick(req, ptr);
  assign gnt_vld = pick[IDX_W];
  assign gnt_idx = pick[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (gnt_vld) ptr <= (int'(gnt_idx) == N-1) ? '0 : gnt_idx + IDX_W'(1);
  end
endmodule

// File: rtl/xbar_out_mux.sv
module xbar_out_mux #(
  parameter int N_IN = 4,
  parameter int W    = 16,
  localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic [N_IN-1:0]         in_valid,
  input  logic [N_IN-1:0][W-1:0]  in_data,
  input  logic [IDX_W-1:0]        sel,
  input  logic                    en,
  output logic                    out_valid,
  output logic [W-1:0]            out_data
);
  always_comb begin
    out_valid = en & in_valid[sel];
    out_data  = en ? in_data[sel] : '0;
  end
endmodule

// File: rtl/xbar_switch.sv
module xbar_switch
  import xbar_pkg::*;
#(
  parameter int N_IN    = 4,
  parameter int N_OUT   = 4,
  parameter int W       = 16,
  parameter int DST_LSB = 0,
  parameter int BL_LSB  = 4,
  localparam int DST_W  = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int IDX_W  = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_IN-1:0]             in_valid,
  input  logic [N_IN-1:0][W-1:0]      in_data,
  output logic [N_IN-1:0]             in_ready,
  output logic [N_OUT-1:0]            out_valid,
  output logic [N_OUT-1:0][W-1:0]     out_data,
  input  logic [N_OUT-1:0]            out_ready,
  output logic [N_IN-1:0]             row_en,
  output logic [N_OUT-1:0]            col_en
);
  // header field extraction
  logic [N_IN-1:0][DST_W-1:0] dst_f;
  logic [N_IN-1:0][BL_W-1:0]  bl_f;
  logic [N_IN-1:0][N_OUT-1:0] dest_oh;
  logic [N_IN-1:0][LEN_W-1:0] pkt_len;

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      dst_f[i] = in_data[i][DST_LSB +: DST_W];
      bl_f[i]  = in_data[i][BL_LSB +: BL_W];
    end
  end

  xbar_route_decode #(.N_IN(N_IN), .N_OUT(N_OUT), .DST_W(DST_W)) u_dec (
    .dst_f(dst_f), .bl_f(bl_f), .dest_oh(dest_oh), .pkt_len(pkt_len)
  );

  // path state per output
  logic [N_OUT-1:0]            busy;
  logic [N_OUT-1:0][IDX_W-1:0] owner;
  logic [N_OUT-1:0][LEN_W-1:0] left;

  // named internal events
  logic [N_IN-1:0]             bound;
  logic [N_OUT-1:0][N_IN-1:0]  req_m;
  logic [N_OUT-1:0]            grant_ev;
  logic [N_OUT-1:0][IDX_W-1:0] grant_idx;
  logic [N_OUT-1:0]            xfer;
  logic [N_OUT-1:0]            last_xfer;

  always_comb begin
    bound = '0;
    for (int o = 0; o < N_OUT; o++)
      for (int i = 0; i < N_IN; i++)
        if (busy[o] && owner[o] == IDX_W'(i)) bound[i] = 1'b1;
  end

  always_comb begin
    for (int o = 0; o < N_OUT; o++)
      for (int i = 0; i < N_IN; i++)
        req_m[o][i] = !busy[o] && in_valid[i] && !bound[i] && dest_oh[i][o];
  end

  generate
    for (genvar o = 0; o < N_OUT; o++) begin : g_col
      xbar_rr_arbiter #(.N(N_IN)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(req_m[o]),
        .gnt_vld(grant_ev[o]), .gnt_idx(grant_idx[o])
      );
      xbar_out_mux #(.N_IN(N_IN), .W(W)) u_mux (
        .in_valid(in_valid), .in_data(in_data), .sel(owner[o]), .en(busy[o]),
        .out_valid(out_valid[o]), .out_data(out_data[o])
      );
      assign xfer[o]      = out_valid[o] && out_ready[o];
      assign last_xfer[o] = xfer[o] && (left[o] == LEN_W'(1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= '0;
      owner <= '0;
      left  <= '0;
    end else begin
      for (int o = 0; o < N_OUT; o++) begin
        if (grant_ev[o]) begin
          busy[o]  <= 1'b1;
          owner[o] <= grant_idx[o];
          left[o]  <= pkt_len[grant_idx[o]];
        end else if (last_xfer[o]) begin
          busy[o]  <= 1'b0;
        end else if (xfer[o]) begin
          left[o]  <= left[o] - LEN_W'(1);
        end
      end
    end
  end

  // back-pressure: only a bound input sees its output's ready
  always_comb begin
    in_ready = '0;
    for (int o = 0; o < N_OUT; o++)
      for (int i = 0; i < N_IN; i++)
        if (busy[o] && owner[o] == IDX_W'(i) && out_ready[o]) in_ready[i] = 1'b1;
  end

  assign row_en = bound;
  assign col_en = busy;
endmodule

// File: rtl/xbar_switch_chk.sv
module xbar_switch_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_IN-1:0]  in_ready,
  input logic [N_OUT-1:0] out_valid,
  input logic [N_OUT-1:0] out_ready,
  input logic [N_IN-1:0]  row_en,
  input logic [N_OUT-1:0] col_en,
  input logic [N_OUT-1:0] grant_ev
);
  assert_paths_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(row_en) == $countones(col_en));

  generate
    for (genvar i = 0; i < N_IN; i++) begin : g_row
      assert_unbound_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !row_en[i] |-> !in_ready[i]);
    end
    for (genvar o = 0; o < N_OUT; o++) begin : g_col
      assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !col_en[o] |-> !out_valid[o]);
      assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (col_en[o] && !out_ready[o]) |=> col_en[o]);
      assert_grant_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
        grant_ev[o] |=> col_en[o]);
      assert_no_regrant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        col_en[o] |-> !grant_ev[o]);
    end
  endgenerate
endmodule

bind xbar_switch xbar_switch_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .row_en(row_en), .col_en(col_en), .grant_ev(grant_ev)
);

// File: tb/xbar_switch_test.sv
`timescale 1ns/1ps
module xbar_switch_test;
  localparam int NI = 4, NO = 4, W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NI-1:0] in_valid = '0;
  logic [NI-1:0][W-1:0] in_data = '0;
  logic [NI-1:0] in_ready;
  logic [NO-1:0] out_valid;
  logic [NO-1:0][W-1:0] out_data;
  logic [NO-1:0] out_ready = '1;
  logic [NI-1:0] row_en;
  logic [NO-1:0] col_en;

  int n_tests = 0, n_fail = 0, cycles = 0;
  int exp_ptr [NO];

  always #10 clk = ~clk;

  xbar_switch #(.N_IN(NI), .N_OUT(NO), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .row_en(row_en), .col_en(col_en)
  );

  function automatic int exp_len(int code);
    return 1 + (1 << code);
  endfunction

  function automatic int exp_winner(bit [NI-1:0] pend, int ptr);
    for (int k = 0; k < NI; k++)
      if (pend[(ptr + k) % NI]) return (ptr + k) % NI;
    return -1;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(0, "watchdog", cycles, 150000);
      finish_run();
    end
  end

  task automatic send_pkt(int i, int dst, int code, int stall_pct);
    logic [W-1:0] hdr, cur;
    int len, k;
    hdr = W'($urandom);
    hdr[1:0] = dst[1:0];
    hdr[5:4] = code[1:0];
    len = exp_len(code);
    @(negedge clk);
    in_valid[i] = 1'b1;
    in_data[i] = hdr;
    out_ready[dst] = 1'b1;
    #1;
    chk(in_ready[i] == 1'b0, "R4 header held in request cycle", in_ready[i], 0);
    chk(out_valid[dst] == 1'b0, "R10 idle output quiet", out_valid[dst], 0);
    @(posedge clk);
    k = 0;
    cur = hdr;
    while (k < len) begin
      @(negedge clk);
      in_data[i] = cur;
      out_ready[dst] = ($urandom % 100) >= stall_pct;
      #1;
      chk(col_en[dst] && row_en[i], "R8 path enables set", {row_en[i], col_en[dst]}, 3);
      chk(out_valid[dst] && out_data[dst] == cur, "R2 R9 flit forwarded", out_data[dst], cur);
      chk(in_ready[i] == out_ready[dst], "R7 ready follows sink", in_ready[i], out_ready[dst]);
      @(posedge clk);
      if (out_ready[dst]) begin
        k++;
        cur = W'($urandom);
      end
    end
    @(negedge clk);
    in_valid[i] = 1'b0;
    exp_ptr[dst] = (i + 1) % NI;
    #1;
    chk(!col_en[dst] && !row_en[i], "R3 path released after last flit", {row_en[i], col_en[dst]}, 0);
  endtask

  initial begin
    void'($urandom(32'd20250611));
    for (int o = 0; o < NO; o++) exp_ptr[o] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == '0 && in_ready == '0 && row_en == '0 && col_en == '0,
        "R1 reset state", {out_valid, in_ready, row_en, col_en}, 0);
    in_valid = '1;
    in_data = '0;
    #1;
    chk(in_ready == '0, "R1 no ready under reset", in_ready, 0);
    in_valid = '0;
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(col_en == '0 && row_en == '0, "R1 state after reset", {row_en, col_en}, 0);

    // directed: every burst code, no stalls
    for (int c = 0; c < 4; c++) send_pkt(c, 3 - c, c, 0);

    // directed: two disjoint paths in parallel
    fork
      send_pkt(0, 1, 2, 30);
      send_pkt(2, 3, 3, 30);
    join

    // constrained random packets with random sink stalls
    for (int n = 0; n < 40; n++)
      send_pkt(int'($urandom % NI), int'($urandom % NO), int'($urandom % 4), 35);

    // directed contention: inputs 0..2 all target output 3, code 0
    begin
      bit [NI-1:0] pend;
      int w;
      logic [W-1:0] pl;
      pend = 4'b0111;
      @(negedge clk);
      out_ready[3] = 1'b1;
      for (int i = 0; i < 3; i++) begin
        in_valid[i] = 1'b1;
        in_data[i] = W'(16'h0A00 | (i << 8) | 16'h0003);
      end
      for (int r = 0; r < 3; r++) begin
        @(posedge clk);
        @(negedge clk);
        #1;
        w = exp_winner(pend, exp_ptr[3]);
        chk(row_en == NI'(1 << w), "R5 round-robin winner", row_en, 1 << w);
        chk(in_ready == NI'(1 << w), "R6 losers stalled", in_ready, 1 << w);
        @(posedge clk);
        @(negedge clk);
        pl = W'($urandom);
        in_data[w] = pl;
        #1;
        chk(out_data[3] == pl, "R2 payload after header", out_data[3], pl);
        @(posedge clk);
        @(negedge clk);
        in_valid[w] = 1'b0;
        pend[w] = 1'b0;
        exp_ptr[3] = (w + 1) % NI;
        #1;
        chk(col_en[3] == 1'b0, "R3 two-flit packet released", col_en[3], 0);
      end
    end
    finish_run();
  end
endmodule